// File: doc/BRIEF.md
# EEPROM Row Write Latch and Program Sequencer

This block sits between the serial protocol engine of a small byte-addressed EEPROM and its storage array. While a write transaction is open, each data byte handed over by the protocol engine is placed into a row-wide holding latch. A per-position valid mask records which positions of the row have been filled. The first accepted byte fixes the row and the starting position. Later bytes advance a position pointer that moves only inside the row and wraps at its end, so an overlong burst overwrites the earliest positions.

When the protocol engine reports the closing STOP of a write, the block starts a self-timed program cycle if at least one byte is held. During that cycle it raises `busy` and drives the array write port once for each filled position, in ascending order. Unfilled positions keep their old array contents. While `busy` is high the block ignores every input, so the protocol engine can refuse bus traffic. The cycle length is a clock-tick count parameter, which lets a bench shorten the nominal 10 ms. After the cycle the mask is cleared, and one settling clock follows before new bytes are taken.

A write-protect input blocks the latching of data bytes. A STOP that closes a write with nothing latched therefore starts no cycle.

Top module: `eeprom_row_programmer`

## Requirements
- R1: With `busy` low and outside the settling clock, a `byte_vld` pulse with `wr_inhibit` low latches `byte_data`. The first byte of a transaction takes its row from `start_addr[10:4]` and its position from `start_addr[3:0]`. Each later byte goes to the position that follows the previous one.
- R2: The position pointer advances only in its low 4 bits, so after position 15 it returns to position 0 of the same row. A byte loaded into a position that is already filled replaces the earlier value.
- R3: A `stop` pulse while at least one position is filled raises `busy` on the clock edge that samples it.
- R4: `busy` stays high for exactly `PROG_TICKS` consecutive clocks. `PROG_TICKS` must be at least `ROW_BYTES + 2`.
- R5: During the cycle, `arr_we` pulses once for each filled position and never for an unfilled one, in ascending position order. Each pulse carries `arr_addr = {row, position}` and `arr_wdata` = the last byte latched at that position. `arr_we` is never high while `busy` is low.
- R6: `byte_vld` and `stop` have no effect while `busy` is high.
- R7: A `byte_vld` pulse with `wr_inhibit` high latches nothing. A following `stop` then starts no cycle and writes nothing.
- R8: A `stop` with no filled positions leaves `busy` low and produces no array write.
- R9: When `busy` falls, the valid mask is already empty. A `byte_vld` in the first clock after the fall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | ADDR_W | Byte address of the first data byte of a write transaction |
| byte_vld | input | 1 | One-clock strobe: a data byte is offered |
| byte_data | input | DATA_W | Data byte that goes with `byte_vld` |
| wr_inhibit | input | 1 | High: offered data bytes are discarded |
| stop | input | 1 | One-clock strobe: the write transaction has ended |
| busy | output | 1 | High for the whole program cycle |
| arr_we | output | 1 | Array write enable, one clock per byte |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The program path is tried with the following patterns:
- **A single byte at an odd address.** This shows that the row and the start position are taken from `start_addr`.
- **A full aligned row of sixteen bytes.** This shows both the ascending write order and the exact busy length.
- **An 18-byte burst that starts four positions before the end of a row.** Only this pattern separates a wrapping pointer from a carrying one, and it checks that the overwritten positions carry the newest values.
- **A three-byte burst in the middle of a row.** This shows that unfilled positions produce no write.

Inhibited bytes, an empty STOP, traffic injected during `busy`, and a byte offered in the settling clock are each followed by a STOP. A missing or spurious cycle then shows whether anything was latched.

// File: rtl/eeprom_row_pkg.sv
// Shared types of the EEPROM row program block.
package eeprom_row_pkg;
    // Program sequencer states.
    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,   // accepting bytes and STOP
        SEQ_PROG   = 2'd1,   // timed program cycle, inputs ignored
        SEQ_SETTLE = 2'd2    // one clock after the cycle, inputs ignored
    } seq_state_t;
endpackage

// File: rtl/eeprom_row_latch.sv
// Row holding latch: stores the data bytes of one write transaction together
// with a per-position valid mask, the row number and the in-row pointer.
// Assumes: `accept` is high only when the sequencer is idle; `clr` arrives
// only at the end of a program cycle; ROW_BYTES is a power of two.
module eeprom_row_latch #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ROW_BYTES = 16,
    localparam int POS_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = ADDR_W - POS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 byte_vld,
    input  logic                 wr_inhibit,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [DATA_W-1:0]    byte_data,
    input  logic                 clr,
    input  logic [POS_W-1:0]     rd_pos,
    output logic [ROW_BYTES-1:0] mask,
    output logic [ROW_W-1:0]     row,
    output logic [DATA_W-1:0]    rd_data
);
    logic [DATA_W-1:0] lat_q [ROW_BYTES];
    logic [POS_W-1:0]  ptr_q;
    logic [POS_W-1:0]  wr_pos;
    logic              take;

    // Decide whether this clock latches a byte and at which position.
    always_comb begin
        take   = accept && byte_vld && !wr_inhibit;
        wr_pos = (mask == '0) ? start_addr[POS_W-1:0] : ptr_q;
    end

    // Row number, pointer and valid mask bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            row   <= '0;
            ptr_q <= '0;
        end else if (clr) begin
            mask <= '0;
        end else if (take) begin
            if (mask == '0) row <= start_addr[ADDR_W-1:POS_W];
            mask[wr_pos] <= 1'b1;
            ptr_q        <= wr_pos + 1'b1;   // wraps inside the row
        end
    end

    // One storage register per row position.
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_pos
        always_ff @(posedge clk) begin
            if (!rst_n)
                lat_q[g] <= '0;
            else if (take && wr_pos == POS_W'(g))
                lat_q[g] <= byte_data;
        end
    end

    assign rd_data = lat_q[rd_pos];
endmodule

// File: rtl/eeprom_prog_seq.sv
// Program sequencer: on STOP with a non-empty mask, runs a fixed-length
// program cycle, scanning the row positions in ascending order and issuing
// one array write per filled position. Ends with one settling clock.
// Assumes: PROG_TICKS >= ROW_BYTES + 2.
module eeprom_prog_seq
    import eeprom_row_pkg::*;
#(
    parameter int ROW_BYTES  = 16,
    parameter int PROG_TICKS = 400000,
    localparam int POS_W     = $clog2(ROW_BYTES),
    localparam int CNT_W     = $clog2(PROG_TICKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop,
    input  logic [ROW_BYTES-1:0] mask,
    output logic                 busy,
    output logic                 idle,
    output logic                 clr,
    output logic                 we,
    output logic [POS_W-1:0]     pos
);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PROG_TICKS - 1);
    localparam logic [CNT_W-1:0] SCAN_END  = CNT_W'(ROW_BYTES);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Status decode.
    always_comb begin
        busy = (state_q == SEQ_PROG);
        idle = (state_q == SEQ_IDLE);
        clr  = busy && (cnt_q == LAST_TICK);
    end

    // State, tick counter and registered array write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            we      <= 1'b0;
            pos     <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    we    <= 1'b0;
                    cnt_q <= '0;
                    if (stop && mask != '0) state_q <= SEQ_PROG;
                end
                SEQ_PROG: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < SCAN_END) begin
                        we  <= mask[cnt_q[POS_W-1:0]];
                        pos <= cnt_q[POS_W-1:0];
                    end else begin
                        we  <= 1'b0;
                    end
                    if (cnt_q == LAST_TICK) state_q <= SEQ_SETTLE;
                end
                default: begin
                    we      <= 1'b0;
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/eeprom_row_programmer.sv
// Top of the row program block: joins the row latch and the program
// sequencer and forms the array write port from the row number, the scan
// position and the latched byte. Assumes the array is external and
// single-ported, taking one byte per clock.
module eeprom_row_programmer #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int ROW_BYTES  = 16,
    parameter int PROG_TICKS = 400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              wr_inhibit,
    input  logic              stop,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int POS_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - POS_W;

    logic [ROW_BYTES-1:0] load_mask;
    logic [ROW_W-1:0]     row_q;
    logic [POS_W-1:0]     scan_pos;
    logic                 seq_idle;
    logic                 seq_clr;

    eeprom_row_latch #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .accept(seq_idle), .byte_vld(byte_vld),
        .wr_inhibit(wr_inhibit), .start_addr(start_addr), .byte_data(byte_data),
        .clr(seq_clr), .rd_pos(scan_pos), .mask(load_mask), .row(row_q),
        .rd_data(arr_wdata)
    );

    eeprom_prog_seq #(
        .ROW_BYTES(ROW_BYTES), .PROG_TICKS(PROG_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .stop(stop), .mask(load_mask), .busy(busy),
        .idle(seq_idle), .clr(seq_clr), .we(arr_we), .pos(scan_pos)
    );

    assign arr_addr = {row_q, scan_pos};
endmodule

// File: rtl/eeprom_row_programmer_chk.sv
// Property checker for eeprom_row_programmer, attached by bind.
module eeprom_row_programmer_chk #(
    parameter int ADDR_W     = 11,
    parameter int ROW_BYTES  = 16,
    parameter int PROG_TICKS = 400000,
    localparam int POS_W     = $clog2(ROW_BYTES),
    localparam int ROW_W     = ADDR_W - POS_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 byte_vld,
    input logic                 wr_inhibit,
    input logic                 stop,
    input logic                 busy,
    input logic                 arr_we,
    input logic [ADDR_W-1:0]    arr_addr,
    input logic [ROW_BYTES-1:0] mask,
    input logic [ROW_W-1:0]     row
);
    logic [31:0] run_q;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    p_start_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop) && $past(mask) != '0);
    p_busy_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == PROG_TICKS);
    p_we_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    p_we_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> arr_addr[ADDR_W-1:POS_W] == row);
    p_busy_blocks_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && byte_vld && $past(busy)) |=> (mask == '0 || $stable(mask)));
    p_inhibit_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && wr_inhibit && !busy) |=> $stable(mask));
    p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !busy && mask == '0) |=> !busy);
    p_mask_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> mask == '0);
endmodule

bind eeprom_row_programmer eeprom_row_programmer_chk #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .PROG_TICKS(PROG_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .wr_inhibit(wr_inhibit),
    .stop(stop), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .mask(load_mask), .row(row_q)
);

// File: tb/eeprom_row_programmer_tb.sv
// Scoreboard bench: the driver tasks keep a model of the row latch built
// from the requirements and push expected array writes into queues; a
// monitor pops and compares every write the design produces.
module eeprom_row_programmer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int DATA_W     = 8;
    localparam int ROWB       = 16;
    localparam int TICKS      = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              byte_vld = 1'b0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              wr_inhibit = 1'b0;
    logic              stop = 1'b0;
    logic              busy;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    // Requirement-level model of the latch.
    logic [ROWB-1:0]   m_mask = '0;
    logic [6:0]        m_row  = '0;
    logic [3:0]        m_ptr  = '0;
    logic [DATA_W-1:0] m_lat [ROWB];
    logic [ADDR_W-1:0] q_addr [$];
    logic [DATA_W-1:0] q_data [$];
    logic [DATA_W-1:0] mem [2048];

    eeprom_row_programmer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROWB), .PROG_TICKS(TICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .byte_vld(byte_vld),
        .byte_data(byte_data), .wr_inhibit(wr_inhibit), .stop(stop),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: every array write must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R5 unexpected write", int'(arr_addr), 0);
            end else begin
                logic [ADDR_W-1:0] ea;
                logic [DATA_W-1:0] ed;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                check(arr_addr == ea, "R5 write address", int'(arr_addr), int'(ea));
                check(arr_wdata == ed, "R5 write data", int'(arr_wdata), int'(ed));
                check(busy == 1'b1, "R5 write inside busy", int'(busy), 1);
                mem[arr_addr] = arr_wdata;
            end
        end
    end

    // Offer one byte; `taken` says whether the requirements make it latch.
    task automatic load_byte(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input bit inh, input bit taken);
        @(negedge clk);
        start_addr = a; byte_data = d; wr_inhibit = inh; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; wr_inhibit = 1'b0;
        if (taken && !inh) begin
            logic [3:0] p;
            p = (m_mask == '0) ? a[3:0] : m_ptr;
            if (m_mask == '0) m_row = a[10:4];
            m_lat[p] = d; m_mask[p] = 1'b1; m_ptr = p + 4'd1;
        end
    endtask

    // STOP; then track busy, optionally injecting traffic during busy (R6)
    // and in the settling clock (R9).
    task automatic do_stop(input bit inject_busy, input bit inject_settle, input string req);
        bit exp_busy;
        int cnt;
        exp_busy = (m_mask != '0);
        if (exp_busy)
            for (int p = 0; p < ROWB; p++)
                if (m_mask[p]) begin
                    q_addr.push_back({m_row, 4'(p)});
                    q_data.push_back(m_lat[p]);
                end
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        check(busy == exp_busy, req, int'(busy), int'(exp_busy));
        cnt = 0;
        while (busy && cnt < 4 * TICKS) begin
            cnt++;
            if (inject_busy && cnt == 3) begin
                start_addr = 11'h7F0; byte_data = 8'hEE; byte_vld = 1'b1; stop = 1'b1;
            end else begin
                byte_vld = 1'b0; stop = 1'b0;
            end
            @(negedge clk);
        end
        byte_vld = 1'b0; stop = 1'b0;
        if (exp_busy) begin
            check(cnt == TICKS, "R4 busy length", cnt, TICKS);
            check(q_addr.size() == 0, "R5 all expected writes seen", q_addr.size(), 0);
            m_mask = '0;
        end
        if (inject_settle) begin
            start_addr = 11'h0A0; byte_data = 8'h77; byte_vld = 1'b1;
            @(negedge clk);
            byte_vld = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
        for (int i = 0; i < ROWB; i++) m_lat[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R3 reset busy low", int'(busy), 0);
        check(arr_we == 1'b0, "R5 reset no write", int'(arr_we), 0);

        // R1: single byte at an odd address.
        load_byte(11'h123, 8'h5A, 1'b0, 1'b1);
        do_stop(1'b0, 1'b0, "R3 busy after stop (single byte)");
        check(mem[11'h123] == 8'h5A, "R1 single byte stored", mem[11'h123], 8'h5A);
        check(mem[11'h124] == 8'hFF, "R5 neighbour untouched", mem[11'h124], 8'hFF);

        // R1/R5: full aligned row.
        for (int i = 0; i < 16; i++) load_byte(11'h230, 8'(8'h10 + i), 1'b0, 1'b1);
        do_stop(1'b0, 1'b0, "R3 busy after stop (full row)");

        // R2: 18 bytes from position 12 wrap and overwrite positions 12, 13.
        for (int i = 0; i < 18; i++) load_byte(11'h3FC, 8'(8'hA0 + i), 1'b0, 1'b1);
        do_stop(1'b0, 1'b0, "R3 busy after stop (wrap)");
        check(mem[11'h3FC] == 8'hB0, "R2 wrapped overwrite", mem[11'h3FC], 8'hB0);
        check(mem[11'h3FE] == 8'hA2, "R2 non-overwritten keeps", mem[11'h3FE], 8'hA2);
        check(mem[11'h400] == 8'hFF, "R2 no carry into next row", mem[11'h400], 8'hFF);

        // R5: partial burst in the middle of a row.
        for (int i = 0; i < 3; i++) load_byte(11'h455, 8'(8'hC0 + i), 1'b0, 1'b1);
        do_stop(1'b0, 1'b0, "R3 busy after stop (partial)");
        check(mem[11'h454] == 8'hFF, "R5 unfilled position kept", mem[11'h454], 8'hFF);

        // R7: inhibited bytes latch nothing.
        for (int i = 0; i < 3; i++) load_byte(11'h500, 8'h33, 1'b1, 1'b1);
        do_stop(1'b0, 1'b0, "R7 no cycle after inhibited bytes");
        check(mem[11'h500] == 8'hFF, "R7 array unchanged", mem[11'h500], 8'hFF);

        // R8: empty STOP.
        do_stop(1'b0, 1'b0, "R8 empty stop leaves busy low");

        // R6 and R9: traffic during busy and in the settling clock.
        load_byte(11'h612, 8'h99, 1'b0, 1'b1);
        do_stop(1'b1, 1'b1, "R3 busy after stop (injection run)");
        do_stop(1'b0, 1'b0, "R6 R9 ignored bytes start no cycle");
        check(mem[11'h7F0] == 8'hFF, "R6 byte during busy not written", mem[11'h7F0], 8'hFF);
        check(mem[11'h0A0] == 8'hFF, "R9 settling byte not written", mem[11'h0A0], 8'hFF);

        repeat (4) @(negedge clk);
        check(q_addr.size() == 0, "R5 scoreboard drained", q_addr.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule